// File: doc/BRIEF.md
# Stopwatch Timekeeping Chain

This block turns a slow clock-enable tick, nominally arriving 32768 times per second from a watch crystal domain, into minutes-and-seconds time of day for a stopwatch face. A binary prescaler of `PRESCALE_BITS` stages (15 by default) counts accepted ticks. It emits a single-cycle one-second pulse each time it wraps. That pulse advances four cascaded BCD digits: seconds units, seconds tens, minutes units and minutes tens.

The units digits count modulo ten and the tens digits count modulo six. The display therefore runs from 00:00 to 59:59 and then wraps back to 00:00. Each digit feeds its own BCD-to-seven-segment decoder, so the outputs can drive a static display directly.

A `run` input freezes the prescaler and the digits. A `clear` input zeroes them synchronously. All state lives in the system clock domain, and the tick is only an enable.

Top module: `stopwatch_chain`

## Requirements
- R1: `sec_pulse` is high for exactly one clock cycle. That cycle is the one in which the 2^`PRESCALE_BITS`-th accepted tick since the last wrap or clear is presented (32768 ticks by default). The digits advance on the same clock edge.
- R2: The seconds units digit counts 0 through 9. On its tenth advance it returns to 0 and advances the seconds tens digit.
- R3: The seconds tens digit counts modulo 6. Time xx:59 becomes (xx+1):00, so 00:59 is followed by 01:00.
- R4: The minutes units digit counts 0 through 9. On wrap it advances the minutes tens digit, so 09:59 is followed by 10:00.
- R5: The minutes tens digit counts modulo 6, so 59:59 is followed by 00:00.
- R6: While `run` is low, ticks are ignored. The prescaler phase and all digits hold, and `sec_pulse` stays low.
- R7: `clear` high zeroes the prescaler and all digits on the next clock edge, whatever the value of `run` or `tick_32k`. `sec_pulse` is low while `clear` is high.
- R8: After synchronous reset (`rst` high), all digits are 0, `sec_pulse` is low, and every segment output shows the pattern for 0.
- R9: Segment outputs are active high, with bit 6 = g down to bit 0 = a. The patterns are 0→0x3F, 1→0x06, 2→0x5B, 3→0x4F, 4→0x66, 5→0x6D, 6→0x7D, 7→0x07, 8→0x7F and 9→0x6F. Any code from 10 to 15 gives 0x00.
- R10: No digit ever holds a value at or above its modulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_32k | input | 1 | Clock-enable tick from the crystal-rate domain |
| run | input | 1 | High lets ticks count; low freezes time |
| clear | input | 1 | Synchronous zero of prescaler and digits |
| sec_units | output | 4 | BCD seconds units |
| sec_tens | output | 4 | BCD seconds tens |
| min_units | output | 4 | BCD minutes units |
| min_tens | output | 4 | BCD minutes tens |
| seg_sec_units | output | 7 | Segments for seconds units, gfedcba |
| seg_sec_tens | output | 7 | Segments for seconds tens, gfedcba |
| seg_min_units | output | 7 | Segments for minutes units, gfedcba |
| seg_min_tens | output | 7 | Segments for minutes tens, gfedcba |
| sec_pulse | output | 1 | One-cycle pulse per elapsed second |

## Verification
The assertions take for granted that `tick_32k`, `run` and `clear` are synchronous to `clk` and settle before each rising edge. They also rely on the digits being reachable only by counting from reset or clear, so no out-of-range code can ever enter a digit.

The bench drives every input at the falling edge and samples outputs at the next falling edge. It walks a full hour on a second instance built with a one-stage prescaler, which keeps the run short. A separate pass over 32768 ticks on the default instance proves the true one-second ratio.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int DIGIT_W = 4;
  localparam int SEG_W   = 7;
  localparam int N_DIGITS = 4;

  // Units digits (even index) are decimal, tens digits (odd index) are modulo six.
  function automatic int unsigned digit_modulus(int idx);
    return (idx % 2 == 0) ? 10 : 6;
  endfunction

  // Next value of a digit given its modulus: wraps to zero at the terminal state.
  function automatic logic [DIGIT_W-1:0] digit_step(logic [DIGIT_W-1:0] v, int unsigned m);
    if (v == DIGIT_W'(m - 1)) return '0;
    return DIGIT_W'(v + 1'b1);
  endfunction

  // Active-high segments, bit 6 = g ... bit 0 = a; non-decimal codes are blank.
  function automatic logic [SEG_W-1:0] bcd_to_seg(logic [DIGIT_W-1:0] d);
    case (d)
      4'd0: return 7'h3F;
      4'd1: return 7'h06;
      4'd2: return 7'h5B;
      4'd3: return 7'h4F;
      4'd4: return 7'h66;
      4'd5: return 7'h6D;
      4'd6: return 7'h7D;
      4'd7: return 7'h07;
      4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/sw_prescaler.sv
module sw_prescaler #(
  parameter int BITS = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic wrap
);
  localparam logic [BITS-1:0] LAST = {BITS{1'b1}};

  logic [BITS-1:0] phase;
  logic            accept;

  assign accept = tick & run & ~clear;
  assign wrap   = accept & (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) phase <= '0;
    else if (accept)  phase <= phase + 1'b1;
  end

  // R1: after a wrap the phase restarts from zero
  a_r1_wrap_restarts: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (phase == '0));
  // R6: frozen while run is low
  a_r6_phase_holds: assert property (@(posedge clk) disable iff (rst)
    (!run && !clear) |=> $stable(phase));
  // R7: clear zeroes the phase
  a_r7_phase_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> (phase == '0));
endmodule

// File: rtl/sw_digit.sv
module sw_digit
  import sw_pkg::*;
#(
  parameter int unsigned MODULUS = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               adv,
  output logic [DIGIT_W-1:0] val,
  output logic               carry
);
  localparam logic [DIGIT_W-1:0] TERM = DIGIT_W'(MODULUS - 1);

  assign carry = adv & (val == TERM);

  always_ff @(posedge clk) begin
    if (rst || clear) val <= '0;
    else if (adv)     val <= digit_step(val, MODULUS);
  end

  // R10: never at or above the modulus
  a_r10_in_range: assert property (@(posedge clk) disable iff (rst)
    val <= TERM);
  // Terminal wrap covers R2, R3, R4 and R5 depending on the modulus of this instance
  a_r2_digit_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && !clear && val == TERM) |=> (val == '0));
  a_r2_digit_step: assert property (@(posedge clk) disable iff (rst)
    (adv && !clear && val != TERM) |=> (val == $past(val) + 1'b1));
  // R6: no advance means hold
  a_r6_digit_holds: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clear) |=> $stable(val));
  // R7: synchronous clear
  a_r7_digit_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> (val == '0));
endmodule

// File: rtl/sw_seg7.sv
module sw_seg7
  import sw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] bcd,
  output logic [SEG_W-1:0]   seg
);
  always_comb seg = bcd_to_seg(bcd);

  // R9: a decimal code always lights at least two segments
  a_r9_decimal_lit: assert property (@(posedge clk) disable iff (rst)
    (bcd <= 4'd9) |-> ($countones(seg) >= 2));
endmodule

// File: rtl/stopwatch_chain.sv
module stopwatch_chain
  import sw_pkg::*;
#(
  parameter int PRESCALE_BITS = 15
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_32k,
  input  logic               run,
  input  logic               clear,
  output logic [DIGIT_W-1:0] sec_units,
  output logic [DIGIT_W-1:0] sec_tens,
  output logic [DIGIT_W-1:0] min_units,
  output logic [DIGIT_W-1:0] min_tens,
  output logic [SEG_W-1:0]   seg_sec_units,
  output logic [SEG_W-1:0]   seg_sec_tens,
  output logic [SEG_W-1:0]   seg_min_units,
  output logic [SEG_W-1:0]   seg_min_tens,
  output logic               sec_pulse
);
  logic [N_DIGITS:0]  adv_chain;
  logic [DIGIT_W-1:0] digit [N_DIGITS];
  logic [SEG_W-1:0]   seg   [N_DIGITS];

  sw_prescaler #(.BITS(PRESCALE_BITS)) u_pre (
    .clk(clk), .rst(rst), .clear(clear), .run(run),
    .tick(tick_32k), .wrap(sec_pulse)
  );

  assign adv_chain[0] = sec_pulse;

  for (genvar i = 0; i < N_DIGITS; i++) begin : g_digit
    sw_digit #(.MODULUS(digit_modulus(i))) u_dig (
      .clk(clk), .rst(rst), .clear(clear), .adv(adv_chain[i]),
      .val(digit[i]), .carry(adv_chain[i+1])
    );
    sw_seg7 u_seg (.clk(clk), .rst(rst), .bcd(digit[i]), .seg(seg[i]));
  end

  assign sec_units     = digit[0];
  assign sec_tens      = digit[1];
  assign min_units     = digit[2];
  assign min_tens      = digit[3];
  assign seg_sec_units = seg[0];
  assign seg_sec_tens  = seg[1];
  assign seg_min_units = seg[2];
  assign seg_min_tens  = seg[3];

  // R5: the hour-level carry out of the top digit only fires at 59:59
  a_r5_hour_wrap: assert property (@(posedge clk) disable iff (rst)
    adv_chain[N_DIGITS] |=> (sec_units == 0 && sec_tens == 0 && min_units == 0 && min_tens == 0));
  // R6: no pulse while stopped
  a_r6_no_pulse_stopped: assert property (@(posedge clk) disable iff (rst)
    !run |-> !sec_pulse);
  // R7: no pulse during clear
  a_r7_no_pulse_clear: assert property (@(posedge clk) disable iff (rst)
    clear |-> !sec_pulse);
  // R3: seconds never exceed 59 as a pair
  a_r3_sec_tens_range: assert property (@(posedge clk) disable iff (rst)
    sec_tens <= 4'd5);
endmodule

// File: tb/sim_stopwatch_chain.sv
module sim_stopwatch_chain;
  localparam int PERIOD = 10;
  localparam int ROWS = 9;
  // each row: seconds to advance (fast instance), expected {mt, mo, st, so}
  localparam int          ADV_SEC [ROWS] = '{1, 8, 1, 49, 1, 539, 1, 2999, 1};
  localparam logic [15:0] EXP_BCD [ROWS] = '{16'h0001, 16'h0009, 16'h0010, 16'h0059,
                                             16'h0100, 16'h0959, 16'h1000, 16'h5959, 16'h0000};

  logic clk = 0, rst = 1, tick_s = 0, tick_f = 0, run = 1, clear = 0;
  logic [3:0] su0, st0, mu0, mt0, su1, st1, mu1, mt1;
  logic [6:0] gsu0, gst0, gmu0, gmt0, gsu1, gst1, gmu1, gmt1;
  logic p0, p1;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  stopwatch_chain u0 (
    .clk(clk), .rst(rst), .tick_32k(tick_s), .run(run), .clear(clear),
    .sec_units(su0), .sec_tens(st0), .min_units(mu0), .min_tens(mt0),
    .seg_sec_units(gsu0), .seg_sec_tens(gst0), .seg_min_units(gmu0), .seg_min_tens(gmt0),
    .sec_pulse(p0));

  stopwatch_chain #(.PRESCALE_BITS(1)) u_fast (
    .clk(clk), .rst(rst), .tick_32k(tick_f), .run(run), .clear(clear),
    .sec_units(su1), .sec_tens(st1), .min_units(mu1), .min_tens(mt1),
    .seg_sec_units(gsu1), .seg_sec_tens(gst1), .seg_min_units(gmu1), .seg_min_tens(gmt1),
    .sec_pulse(p1));

  function automatic logic [6:0] seg_ref(int d);
    logic [6:0] t [10] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07, 7'h7F, 7'h6F};
    return (d >= 0 && d <= 9) ? t[d] : 7'h00;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fast_bcd();
    return {mt1, mu1, st1, su1};
  endfunction

  task automatic fast_ticks(int n);
    repeat (n) begin @(negedge clk); tick_f = 1; end
    @(negedge clk); tick_f = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R8 reset state
    check("R8 digits", {mt0, mu0, st0, su0}, 0);
    check("R8 pulse", p0, 0);
    check("R8 seg", gsu0, 7'h3F);
    check("R8 fast digits", fast_bcd(), 0);

    // R2 R3 R4 R5 R9: table walk through one full hour on the fast instance
    for (int r = 0; r < ROWS; r++) begin
      fast_ticks(2 * ADV_SEC[r]);
      check("R2 R3 R4 R5 table digits", fast_bcd(), EXP_BCD[r]);
      check("R9 seg sec units", gsu1, seg_ref(int'(EXP_BCD[r][3:0])));
      check("R9 seg min tens", gmt1, seg_ref(int'(EXP_BCD[r][15:12])));
      check("R10 sec tens range", (st1 <= 5), 1);
    end

    // R1: default instance needs exactly 32768 ticks per second
    repeat (32767) begin @(negedge clk); tick_s = 1; end
    @(negedge clk); tick_s = 0;
    check("R1 before last tick", su0, 0);
    tick_s = 1;
    #1;
    check("R1 pulse on last tick", p0, 1);
    @(negedge clk); tick_s = 0;
    check("R1 one second", su0, 1);
    check("R1 pulse drops", p0, 0);

    // R6: run low ignores ticks and holds prescaler phase
    fast_ticks(6);
    check("R6 start 00:03", fast_bcd(), 16'h0003);
    run = 0;
    fast_ticks(10);
    check("R6 held digits", fast_bcd(), 16'h0003);
    run = 1;
    fast_ticks(1);
    check("R6 phase held", fast_bcd(), 16'h0003);
    fast_ticks(1);
    check("R6 resumes", fast_bcd(), 16'h0004);

    // R7: clear with odd phase and tick present, then phase restarts
    fast_ticks(1);
    @(negedge clk); clear = 1; tick_f = 1;
    #1;
    check("R7 no pulse in clear", p1, 0);
    @(negedge clk); clear = 0; tick_f = 0;
    check("R7 cleared digits", fast_bcd(), 0);
    check("R7 cleared slow", {mt0, mu0, st0, su0}, 0);
    fast_ticks(1);
    check("R7 phase zeroed", fast_bcd(), 0);
    fast_ticks(1);
    check("R7 counts after clear", fast_bcd(), 16'h0001);
    // R7: clear works while stopped
    run = 0;
    @(negedge clk); clear = 1;
    @(negedge clk); clear = 0;
    check("R7 clear while stopped", fast_bcd(), 0);
    run = 1;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule